// File: doc/BRIEF.md
# Station Address Checksum Verifier

This block takes in a station address as it comes out of a byte-wide address store. It sees six address bytes and then two checksum bytes, one byte in each cycle where the valid strobe is high. While the address bytes arrive, it pairs them into three 16-bit words and folds each word into a running 16-bit checksum. The checksum is an end-around sum: the running value is shifted left by one bit, then the word is added, and 0xFFFF is subtracted whenever an intermediate result goes above 0xFFFF. The two checksum bytes that follow are compared with the final value.

After the eighth byte, the block pulses `done` for one cycle. At the same time it presents the 48-bit address and a flag that says whether the stored checksum matched. The address is always delivered, even when the checksum does not match. A synchronous `clear` drops any partly received frame. It is used when the byte source starts over.

Top module: `ckv_station_check`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `done` is 0, `addr_out` is all zeros and `csum_ok` is 0.
- R2: A byte is consumed only in a cycle where `byte_valid` is 1. Idle cycles between bytes do not change the result, whatever `byte_in` carries during them.
- R3: The six address bytes keep their arrival order. The first byte received appears in `addr_out[47:40]` and the sixth in `addr_out[7:0]`.
- R4: Address bytes are paired as (1,2), (3,4), (5,6). In each pair the earlier byte is the low half of the 16-bit word and the later byte is the high half.
- R5: For each word in turn, the running sum (starting at 0) is doubled, reduced by 0xFFFF if it exceeds 0xFFFF, increased by the word, and reduced by 0xFFFF again if it exceeds 0xFFFF. Example: address 08 00 2B 01 02 03 gives 0x0578.
- R6: If the sum after the third word equals 0xFFFF, it is replaced by 0x0000 before the compare. A stored checksum of 0xFFFF therefore never matches.
- R7: The seventh byte is the low byte and the eighth byte is the high byte of the stored checksum. `csum_ok` is 1 exactly when the stored checksum equals the normalised sum.
- R8: On a mismatch, `csum_ok` is 0 and `addr_out` still carries the received address.
- R9: `done` is 1 for exactly one cycle: the cycle after the clock edge that takes the eighth byte. `addr_out` and `csum_ok` change only in that cycle and hold until the next frame completes or a clear.
- R10: `clear` sampled high drops any partial frame, zeros `addr_out` and `csum_ok`, and makes the next valid byte the first byte of a frame. A byte offered in the same cycle as `clear` is dropped.
- R11: After the eighth byte, the next valid byte starts a new frame with the sum restarted at 0. This holds even when that byte comes in the very next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| clear | input | 1 | Synchronous drop of partial frame and outputs |
| byte_valid | input | 1 | `byte_in` carries a frame byte this cycle |
| byte_in | input | 8 | Frame byte: six address bytes, then checksum low, then checksum high |
| done | output | 1 | One-cycle pulse when a frame has been taken |
| addr_out | output | 48 | Received station address, first byte in the top bits |
| csum_ok | output | 1 | Stored checksum matched the computed one |

## Verification
If the byte counter is wrong, the fault shows at the very next `done`. The pulse comes early or late against the bench's count of offered bytes, or the address bytes land in shifted positions of `addr_out`. If the accumulator or the low-byte holding register is wrong, the only visible symptom is `csum_ok` at the end of that frame. For that reason the stimulus mixes matching, corrupted and 0xFFFF-valued checksums, and includes addresses whose sums cross the fold threshold. A frame that leaks into the next one through a stale sum shows up on the first back-to-back frame, one frame after the cause.

// File: rtl/ckv_pkg.sv
package ckv_pkg;
  localparam int unsigned CKV_BYTE_W = 8;

  typedef enum logic {
    HALF_LO = 1'b0,
    HALF_HI = 1'b1
  } pair_half_e;
endpackage

// File: rtl/ckv_seq.sv
module ckv_seq
  import ckv_pkg::*;
#(
  parameter int unsigned FRAME_BYTES = 8,
  localparam int unsigned IDX_W = $clog2(FRAME_BYTES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             take,
  output logic [IDX_W-1:0] idx,
  output pair_half_e       half,
  output logic             last
);
  logic [IDX_W-1:0] cnt_q, cnt_d;

  always_comb begin
    last = (cnt_q == IDX_W'(FRAME_BYTES - 1));
    half = cnt_q[0] ? HALF_HI : HALF_LO;
    cnt_d = cnt_q;
    if (clear) cnt_d = '0;
    else if (take) cnt_d = last ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign idx = cnt_q;
endmodule

// File: rtl/ckv_fold_step.sv
module ckv_fold_step #(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0] acc,
  input  logic [W-1:0] word,
  output logic [W-1:0] nxt
);
  localparam logic [W+1:0] MAXV = {2'b00, {W{1'b1}}};

  logic [W+1:0] shifted, red1, summed, red2;

  always_comb begin
    shifted = {1'b0, acc, 1'b0};
    red1    = (shifted > MAXV) ? shifted - MAXV : shifted;
    summed  = red1 + {2'b00, word};
    red2    = (summed > MAXV) ? summed - MAXV : summed;
    nxt     = red2[W-1:0];
  end
endmodule

// File: rtl/ckv_accum.sv
module ckv_accum #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         restart,
  input  logic         load,
  input  logic [W-1:0] word,
  output logic [W-1:0] sum_norm
);
  logic [W-1:0] acc_q, acc_d, step;

  ckv_fold_step #(.W(W)) u_step (
    .acc  (acc_q),
    .word (word),
    .nxt  (step)
  );

  always_comb begin
    acc_d = acc_q;
    if (restart)   acc_d = '0;
    else if (load) acc_d = step;
    sum_norm = (acc_q == {W{1'b1}}) ? '0 : acc_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_d;
  end
endmodule

// File: rtl/ckv_station_check.sv
module ckv_station_check
  import ckv_pkg::*;
#(
  parameter int unsigned ADDR_WORDS = 3,
  localparam int unsigned BW          = CKV_BYTE_W,
  localparam int unsigned WORD_W      = 2 * BW,
  localparam int unsigned ADDR_BYTES  = 2 * ADDR_WORDS,
  localparam int unsigned FRAME_BYTES = ADDR_BYTES + 2,
  localparam int unsigned IDX_W       = $clog2(FRAME_BYTES),
  localparam int unsigned ADDR_W      = ADDR_BYTES * BW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              byte_valid,
  input  logic [BW-1:0]     byte_in,
  output logic              done,
  output logic [ADDR_W-1:0] addr_out,
  output logic              csum_ok
);
  logic [IDX_W-1:0]  idx;
  pair_half_e        half;
  logic              last;
  logic              take;
  logic [BW-1:0]     lo_q;
  logic [WORD_W-1:0] pair_word;
  logic [WORD_W-1:0] sum_norm;
  logic              acc_load, acc_restart;
  logic [ADDR_W-1:0] addr_live;
  logic              done_d, ok_d;
  logic [ADDR_W-1:0] addr_d;

  assign take      = byte_valid && !clear;
  assign pair_word = {byte_in, lo_q};

  ckv_seq #(.FRAME_BYTES(FRAME_BYTES)) u_seq (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (clear),
    .take  (byte_valid),
    .idx   (idx),
    .half  (half),
    .last  (last)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          lo_q <= '0;
    else if (take && half == HALF_LO)    lo_q <= byte_in;
  end

  for (genvar gi = 0; gi < ADDR_BYTES; gi++) begin : g_abyte
    logic [BW-1:0] byte_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                           byte_q <= '0;
      else if (take && idx == IDX_W'(gi))   byte_q <= byte_in;
    end
    assign addr_live[(ADDR_BYTES-1-gi)*BW +: BW] = byte_q;
  end

  assign acc_load    = take && half == HALF_HI && idx < IDX_W'(ADDR_BYTES);
  assign acc_restart = clear || (take && last);

  ckv_accum #(.W(WORD_W)) u_accum (
    .clk      (clk),
    .rst_n    (rst_n),
    .restart  (acc_restart),
    .load     (acc_load),
    .word     (pair_word),
    .sum_norm (sum_norm)
  );

  always_comb begin
    done_d = take && last;
    addr_d = addr_out;
    ok_d   = csum_ok;
    if (clear) begin
      addr_d = '0;
      ok_d   = 1'b0;
    end else if (done_d) begin
      addr_d = addr_live;
      ok_d   = (pair_word == sum_norm);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done     <= 1'b0;
      addr_out <= '0;
      csum_ok  <= 1'b0;
    end else begin
      done     <= done_d;
      addr_out <= addr_d;
      csum_ok  <= ok_d;
    end
  end
endmodule

// File: rtl/ckv_station_check_sva.sv
module ckv_station_check_sva #(
  parameter int unsigned ADDR_W = 48
) (
  input logic              clk,
  input logic              rst_n,
  input logic              clear,
  input logic              byte_valid,
  input logic              done,
  input logic [ADDR_W-1:0] addr_out,
  input logic              csum_ok
);
  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_needs_byte_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(byte_valid) && !$past(clear));

  assert_outputs_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!done && !$past(clear)) |-> ($stable(addr_out) && $stable(csum_ok)));

  assert_clear_zeroes_R10: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (!done && addr_out == '0 && !csum_ok));
endmodule

bind ckv_station_check ckv_station_check_sva #(.ADDR_W(ADDR_W)) u_sva (
  .clk        (clk),
  .rst_n      (rst_n),
  .clear      (clear),
  .byte_valid (byte_valid),
  .done       (done),
  .addr_out   (addr_out),
  .csum_ok    (csum_ok)
);

// File: tb/tb_ckv_station_check.sv
module tb_ckv_station_check;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 8;
  // mode: 0 correct checksum, 1 corrupted checksum, 2 stored 0xFFFF
  localparam logic [47:0] VEC_ADDR [NVEC] = '{
    48'h08002B010203, 48'h000000000000, 48'h00000000FFFF, 48'hFFFFFFFFFFFF,
    48'h123456789ABC, 48'hA5A55A5AFF00, 48'h010203040506, 48'hFEDCBA987654};
  localparam int VEC_MODE [NVEC] = '{0, 0, 2, 1, 0, 1, 0, 1};
  localparam int VEC_GAP  [NVEC] = '{0, 1, 0, 2, 0, 3, 1, 0};

  logic clk, rst_n, clear, byte_valid;
  logic [7:0] byte_in;
  logic done, csum_ok;
  logic [47:0] addr_out;
  int total, bad;
  bit finished;

  ckv_station_check dut (
    .clk(clk), .rst_n(rst_n), .clear(clear), .byte_valid(byte_valid),
    .byte_in(byte_in), .done(done), .addr_out(addr_out), .csum_ok(csum_ok));

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [15:0] ref_sum(input logic [47:0] a);
    logic [17:0] s;
    logic [15:0] w;
    s = '0;
    for (int k = 0; k < 3; k++) begin
      w = {a[47-8*(2*k+1) -: 8], a[47-8*(2*k) -: 8]};
      s = s << 1;
      if (s > 18'h0FFFF) s = s - 18'h0FFFF;
      s = s + {2'b00, w};
      if (s > 18'h0FFFF) s = s - 18'h0FFFF;
    end
    if (s == 18'h0FFFF) s = '0;
    return s[15:0];
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send(input logic [47:0] a, input logic [15:0] ck, input int gap, input bit cont);
    for (int i = 0; i < 8; i++) begin
      byte_valid = 1'b1;
      byte_in = (i < 6) ? a[47-8*i -: 8] : (i == 6 ? ck[7:0] : ck[15:8]);
      @(negedge clk);
      if (gap > 0 && i < 7) begin
        byte_valid = 1'b0;
        byte_in = 8'h5A;
        repeat (gap) begin
          @(negedge clk);
          chk(done == 1'b0, "R2 no done during gap", 64'(done), 64'd0);
        end
      end
    end
    if (!cont) byte_valid = 1'b0;
  endtask

  task automatic expect_frame(input logic [47:0] a, input bit ok, input string req);
    chk(done == 1'b1, {req, " done"}, 64'(done), 64'd1);
    chk(addr_out == a, {req, " addr"}, 64'(addr_out), 64'(a));
    chk(csum_ok == ok, {req, " csum_ok"}, 64'(csum_ok), 64'(ok));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] ck;
    logic [47:0] ra;
    total = 0; bad = 0; finished = 0;
    rst_n = 1'b0; clear = 1'b0; byte_valid = 1'b0; byte_in = '0;
    repeat (3) @(negedge clk);
    chk(done == 0 && addr_out == 0 && csum_ok == 0, "R1 in reset", {15'd0, done, addr_out}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(done == 0 && addr_out == 0 && csum_ok == 0, "R1 after reset", {15'd0, done, addr_out}, 64'd0);

    // R5 hand-computed value, R4 pairing, R3 order, R7
    chk(ref_sum(48'h08002B010203) == 16'h0578, "R5 model", 64'(ref_sum(48'h08002B010203)), 64'h0578);
    send(48'h08002B010203, 16'h0578, 0, 0);
    expect_frame(48'h08002B010203, 1'b1, "R5 R4 R3 R7 known");
    @(negedge clk);
    chk(done == 0, "R9 single pulse", 64'(done), 64'd0);
    repeat (3) @(negedge clk);
    chk(addr_out == 48'h08002B010203 && csum_ok, "R9 hold", 64'(addr_out), 64'h08002B010203);
    // R4: byte-swapped stored checksum must not match
    send(48'h08002B010203, 16'h7805, 0, 0);
    expect_frame(48'h08002B010203, 1'b0, "R4 R7 swapped ck");

    for (int v = 0; v < NVEC; v++) begin
      ck = ref_sum(VEC_ADDR[v]);
      if (VEC_MODE[v] == 1) ck = ck ^ 16'h0101;
      if (VEC_MODE[v] == 2) ck = 16'hFFFF;
      send(VEC_ADDR[v], ck, VEC_GAP[v], 0);
      expect_frame(VEC_ADDR[v], VEC_MODE[v] == 0, "R2 R6 R8 vector");
      @(negedge clk);
    end

    // R6: 0xFFFF sum normalised to 0
    send(48'h00000000FFFF, 16'h0000, 0, 0);
    expect_frame(48'h00000000FFFF, 1'b1, "R6 zero match");
    send(48'hFFFFFFFFFFFF, 16'h0000, 1, 0);
    expect_frame(48'hFFFFFFFFFFFF, 1'b1, "R6 all ones");

    // R10: clear mid-frame, byte in clear cycle dropped, outputs zeroed
    send(48'h111111111111, 16'h1234, 0, 0);
    byte_valid = 1'b1; byte_in = 8'hAA; @(negedge clk);
    byte_in = 8'hBB; @(negedge clk);
    clear = 1'b1; byte_in = 8'hCC; @(negedge clk);
    clear = 1'b0; byte_valid = 1'b0;
    chk(addr_out == 0 && csum_ok == 0 && done == 0, "R10 clear zeroes", 64'(addr_out), 64'd0);
    ra = 48'h0A0B0C0D0E0F;
    send(ra, ref_sum(ra), 0, 0);
    expect_frame(ra, 1'b1, "R10 restart");

    // R11: back-to-back frames, random addresses
    void'($urandom(32'h1D2C));
    for (int r = 0; r < 12; r++) begin
      ra = {$urandom, $urandom} ;
      send(ra, ref_sum(ra), r % 3, 1);
      expect_frame(ra, 1'b1, "R11 back-to-back");
    end
    byte_valid = 1'b0;
    ra = 48'h00000000FFFF;
    send(ra, 16'hFFFF, 0, 0);
    expect_frame(ra, 1'b0, "R6 stored ffff");

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule